// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical frame number after a translation-cache miss. It accepts one request at a time over a valid/ready handshake. A request carries the virtual address, the access kind (read, write or instruction fetch) and whether the access comes from user mode. The block then reads 8-byte table entries one at a time through a memory port. It starts from the frame held on the root-table input and descends one radix level per read.

The walk can finish in one of three ways. It reaches a 4 KiB leaf. It stops early on a page-size flag, which gives a 2 MiB or 1 GiB page. Or it stops on a fault. The result is a one-cycle response with the frame number, the page size and the combined permissions, or with a fault code and the level where the fault was found. When a successful leaf lacks its accessed mark, or lacks its dirty mark on a write, the block writes the entry back to the same address before it responds.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress; after a request is accepted it stays low until the response pulse has been given.
- R2: The first read goes to `{root_pfn, va[47:39], 3'b000}`. Each later read goes to `{frame field of the previous entry, next 9-bit index, 3'b000}`, using va[38:30], then va[29:21], then va[20:12]. The levels are numbered 3 (root) down to 0 (leaf table).
- R3: Entry layout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bit 7 page size, bit 63 execute-disable, bits [51:12] frame. A level-0 entry gives `rsp_pfn` equal to its frame field and `rsp_size` 0 (4 KiB), after exactly four reads.
- R4: A present entry at level 1 with page size set ends the walk after three reads. The result has `rsp_size` 1 (2 MiB) and `rsp_pfn` = {entry[51:21], va[20:12]}.
- R5: A present entry at level 2 with page size set ends the walk after two reads. The result has `rsp_size` 2 (1 GiB) and `rsp_pfn` = {entry[51:30], va[29:12]}.
- R6: An entry whose present bit is clear ends the walk with `rsp_fault`=1, `rsp_fcode`=0 and `rsp_flevel` equal to that entry's level. No further reads follow.
- R7: A user access to an entry whose user bit, or whose ancestors' user bit, is clear faults with code 2. This check is made before the write and execute checks.
- R8: A write access where this entry or an ancestor is not writable faults with code 1. This check is made before the execute check.
- R9: An instruction fetch where this entry or an ancestor has execute-disable set faults with code 3.
- R10: On a successful leaf whose accessed bit is clear, the block issues one write to the leaf's address with the same entry and bit 5 set. The write comes before the response.
- R11: On a successful write access, the written-back entry also has bit 6 set, and a leaf with dirty clear is always written back.
- R12: A faulting walk never writes. A successful leaf that already carries the accessed mark, and the dirty mark too when the access is a write, is not written.
- R13: On success, `rsp_w` and `rsp_u` are the AND of that bit over every entry visited, and `rsp_xd` is the OR.
- R14: `rsp_valid` is a single-cycle pulse per accepted request, and no memory request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | Access made from user mode |
| root_pfn | input | 40 | Frame of the root table |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 52 | Entry byte address |
| mem_wdata | output | 64 | Entry value written back |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Entry value read |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fcode | output | 2 | 0 not present, 1 write-protect, 2 privilege, 3 execute-disable |
| rsp_flevel | output | 2 | Level at which the fault was found |
| rsp_pfn | output | 40 | Translated frame number |
| rsp_size | output | 2 | 0 4 KiB, 1 2 MiB, 2 1 GiB |
| rsp_w | output | 1 | Combined writable permission |
| rsp_u | output | 1 | Combined user permission |
| rsp_xd | output | 1 | Combined execute-disable |

## Verification
Some properties are checked on every cycle. Ready drops once a request is taken. The level falls by exactly one between consecutive reads. A write-back always targets the entry just read and carries the accessed mark, plus the dirty mark on write accesses. The response is a single pulse, and the memory port stays quiet while idle. Other behaviours show only in the bench's sweeps, because they depend on the table contents. These are the fault code priority over all flag and access combinations, the level reported for missing entries, the frame splicing of 2 MiB and 1 GiB pages across several offsets, and whether a write-back happens at all.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 52;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 9;
    localparam int LEVELS = 4;
    localparam int ENT_W  = 64;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int ESZ_W  = 3;   // log2 of entry bytes

    // entry flag positions
    localparam int B_P  = 0;
    localparam int B_W  = 1;
    localparam int B_U  = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;
    localparam int B_XD = 63;

    typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2} acc_e;
    typedef enum logic [1:0] {FLT_NP = 2'd0, FLT_WP = 2'd1, FLT_US = 2'd2, FLT_XD = 2'd3} flt_e;
    typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} pgsz_e;

    typedef struct packed {
        logic             p;
        logic             w;
        logic             u;
        logic             a;
        logic             d;
        logic             ps;
        logic             xd;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    function automatic pte_t pte_decode(input logic [ENT_W-1:0] e);
        pte_t t;
        t.p   = e[B_P];
        t.w   = e[B_W];
        t.u   = e[B_U];
        t.a   = e[B_A];
        t.d   = e[B_D];
        t.ps  = e[B_PS];
        t.xd  = e[B_XD];
        t.pfn = e[PA_W-1:OFF_W];
        return t;
    endfunction

    function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va,
                                                  input logic [LVL_W-1:0] lvl);
        return va[OFF_W + int'(lvl) * IDX_W +: IDX_W];
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PFN_W-1:0] base_pfn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  ent_addr
);
    localparam int PAD_W = OFF_W - IDX_W - ESZ_W;

    logic [IDX_W-1:0] idx;
    assign idx = va_index(vaddr, lvl);

    generate
        if (PAD_W > 0) begin : g_pad
            assign ent_addr = {base_pfn, {PAD_W{1'b0}}, idx, {ESZ_W{1'b0}}};
        end else begin : g_nopad
            assign ent_addr = {base_pfn, idx, {ESZ_W{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] lvl,
    input  logic [VA_W-1:0]  vaddr,
    input  acc_e             acc,
    input  logic             user,
    input  logic             w_in,
    input  logic             u_in,
    input  logic             xd_in,
    output logic             fault,
    output flt_e             fcode,
    output logic             leaf,
    output logic [PFN_W-1:0] next_pfn,
    output logic [PFN_W-1:0] leaf_pfn,
    output pgsz_e            leaf_size,
    output logic             eff_w,
    output logic             eff_u,
    output logic             eff_xd,
    output logic             need_wb,
    output logic [ENT_W-1:0] wb_data
);
    pte_t             t;
    logic [PFN_W-1:0] keep_mask;
    logic [PFN_W-1:0] va_pfn;

    assign t        = pte_decode(entry);
    assign eff_w    = w_in & t.w;
    assign eff_u    = u_in & t.u;
    assign eff_xd   = xd_in | t.xd;
    assign next_pfn = t.pfn;

    // large pages are only legal at the 1 GiB and 2 MiB directory levels
    assign leaf = (lvl == '0) ||
                  (t.ps && (lvl == LVL_W'(1) || lvl == LVL_W'(2)));

    always_comb begin
        fault = 1'b0;
        fcode = FLT_NP;
        if (!t.p) begin
            fault = 1'b1;
            fcode = FLT_NP;
        end else if (user && !eff_u) begin
            fault = 1'b1;
            fcode = FLT_US;
        end else if (acc == ACC_WRITE && !eff_w) begin
            fault = 1'b1;
            fcode = FLT_WP;
        end else if (acc == ACC_EXEC && eff_xd) begin
            fault = 1'b1;
            fcode = FLT_XD;
        end
    end

    always_comb begin
        case (lvl)
            LVL_W'(2): leaf_size = PG_1G;
            LVL_W'(1): leaf_size = PG_2M;
            default:   leaf_size = PG_4K;
        endcase
    end

    // low frame bits of a large page come from the virtual address
    assign keep_mask = ~({PFN_W{1'b1}} << (int'(lvl) * IDX_W));
    assign va_pfn    = {{(PFN_W - VPN_W){1'b0}}, vaddr[VA_W-1:OFF_W]};
    assign leaf_pfn  = (t.pfn & ~keep_mask) | (va_pfn & keep_mask);

    always_comb begin
        wb_data       = entry;
        wb_data[B_A]  = 1'b1;
        if (acc == ACC_WRITE) wb_data[B_D] = 1'b1;
        need_wb = !t.a || (acc == ACC_WRITE && !t.d);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [47:0]      req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    input  logic [39:0]      root_pfn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_we,
    output logic [51:0]      mem_addr,
    output logic [63:0]      mem_wdata,
    input  logic             mem_rvalid,
    input  logic [63:0]      mem_rdata,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [1:0]       rsp_fcode,
    output logic [1:0]       rsp_flevel,
    output logic [39:0]      rsp_pfn,
    output logic [1:0]       rsp_size,
    output logic             rsp_w,
    output logic             rsp_u,
    output logic             rsp_xd
);
    typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_RSP} st_e;

    st_e              st;
    logic [LVL_W-1:0] lvl;
    logic [PFN_W-1:0] base;
    logic [VA_W-1:0]  va_q;
    acc_e             acc_q;
    logic             usr_q;
    logic             w_c, u_c, xd_c;
    logic [ENT_W-1:0] wb_q;
    logic [PA_W-1:0]  ent_addr;
    logic [PA_W-1:0]  last_rd_addr;

    logic             c_fault, c_leaf, c_w, c_u, c_xd, c_wb;
    flt_e             c_fcode;
    pgsz_e            c_size;
    logic [PFN_W-1:0] c_next, c_pfn;
    logic [ENT_W-1:0] c_wdata;

    ptw_addr_gen u_addr (
        .base_pfn (base),
        .vaddr    (va_q),
        .lvl      (lvl),
        .ent_addr (ent_addr)
    );

    ptw_entry_check u_chk (
        .entry     (mem_rdata),
        .lvl       (lvl),
        .vaddr     (va_q),
        .acc       (acc_q),
        .user      (usr_q),
        .w_in      (w_c),
        .u_in      (u_c),
        .xd_in     (xd_c),
        .fault     (c_fault),
        .fcode     (c_fcode),
        .leaf      (c_leaf),
        .next_pfn  (c_next),
        .leaf_pfn  (c_pfn),
        .leaf_size (c_size),
        .eff_w     (c_w),
        .eff_u     (c_u),
        .eff_xd    (c_xd),
        .need_wb   (c_wb),
        .wb_data   (c_wdata)
    );

    assign req_ready     = (st == S_IDLE);
    assign rsp_valid     = (st == S_RSP);
    assign mem_req_valid = (st == S_RD) || (st == S_WB);
    assign mem_we        = (st == S_WB);
    assign mem_addr      = ent_addr;
    assign mem_wdata     = wb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            lvl        <= '0;
            base       <= '0;
            va_q       <= '0;
            acc_q      <= ACC_READ;
            usr_q      <= 1'b0;
            w_c        <= 1'b1;
            u_c        <= 1'b1;
            xd_c       <= 1'b0;
            wb_q       <= '0;
            rsp_fault  <= 1'b0;
            rsp_fcode  <= '0;
            rsp_flevel <= '0;
            rsp_pfn    <= '0;
            rsp_size   <= '0;
            rsp_w      <= 1'b0;
            rsp_u      <= 1'b0;
            rsp_xd     <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    va_q  <= req_vaddr;
                    acc_q <= acc_e'(req_acc);
                    usr_q <= req_user;
                    base  <= root_pfn;
                    lvl   <= LVL_W'(LEVELS - 1);
                    w_c   <= 1'b1;
                    u_c   <= 1'b1;
                    xd_c  <= 1'b0;
                    st    <= S_RD;
                end
                S_RD: if (mem_req_ready) st <= S_WAIT;
                S_WAIT: if (mem_rvalid) begin
                    w_c  <= c_w;
                    u_c  <= c_u;
                    xd_c <= c_xd;
                    if (c_fault) begin
                        rsp_fault  <= 1'b1;
                        rsp_fcode  <= c_fcode;
                        rsp_flevel <= lvl;
                        st         <= S_RSP;
                    end else if (c_leaf) begin
                        rsp_fault <= 1'b0;
                        rsp_fcode <= '0;
                        rsp_flevel <= '0;
                        rsp_pfn   <= c_pfn;
                        rsp_size  <= c_size;
                        rsp_w     <= c_w;
                        rsp_u     <= c_u;
                        rsp_xd    <= c_xd;
                        wb_q      <= c_wdata;
                        st        <= c_wb ? S_WB : S_RSP;
                    end else begin
                        base <= c_next;
                        lvl  <= lvl - 1'b1;
                        st   <= S_RD;
                    end
                end
                S_WB:  if (mem_req_ready) st <= S_RSP;
                S_RSP: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_rd_addr <= '0;
        else if (mem_req_valid && mem_req_ready && !mem_we) last_rd_addr <= mem_addr;
    end

    // R1: once a request is taken the walker stops accepting
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2: each descent goes exactly one level down
    p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && mem_rvalid && !c_fault && !c_leaf) |=> (lvl == $past(lvl) - 1'b1));

    // R10: write-back targets the entry just read and marks it accessed
    p_wb_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_we) |-> (mem_addr == last_rd_addr && mem_wdata[B_A]));

    // R11: write accesses leave the dirty mark in the written entry
    p_wb_dirty_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_we && acc_q == ACC_WRITE) |-> mem_wdata[B_D]);

    // R14: single-cycle response, no memory traffic while idle
    p_rsp_pulse_r14: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_idle_quiet_r14: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [39:0] ROOT = 40'h100;
    localparam logic [39:0] T2   = 40'h200;
    localparam logic [39:0] T1   = 40'h300;
    localparam logic [39:0] T0   = 40'h400;
    localparam logic [39:0] LEAF = 40'h12345;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_user = 1'b0;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic mem_req_valid, mem_we, mem_rvalid = 1'b0;
    logic [51:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata = '0;
    logic rsp_valid, rsp_fault, rsp_w, rsp_u, rsp_xd;
    logic [1:0] rsp_fcode, rsp_flevel, rsp_size;
    logic [39:0] rsp_pfn;

    logic [63:0] mem [longint unsigned];
    int rd_total = 0, wr_total = 0;
    logic [51:0] last_rd = '0, last_wr = '0;
    logic [63:0] last_wd = '0;
    int nchk = 0, nfail = 0, cyc = 0;

    // captured result
    logic g_valid, g_pulse, g_busy, g_fault;
    logic [1:0] g_code, g_lvl, g_size;
    logic [39:0] g_pfn;
    logic g_w, g_u, g_xd;
    int g_rd, g_wr;

    ptw_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user), .root_pfn(ROOT),
        .mem_req_valid(mem_req_valid), .mem_req_ready(1'b1), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fcode(rsp_fcode), .rsp_flevel(rsp_flevel), .rsp_pfn(rsp_pfn),
        .rsp_size(rsp_size), .rsp_w(rsp_w), .rsp_u(rsp_u), .rsp_xd(rsp_xd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        mem_rvalid <= mem_req_valid && !mem_we;
        mem_rdata  <= mem.exists(longint'(mem_addr)) ? mem[longint'(mem_addr)] : 64'h0;
        if (mem_req_valid && !mem_we) begin rd_total <= rd_total + 1; last_rd <= mem_addr; end
        if (mem_req_valid && mem_we) begin wr_total <= wr_total + 1; last_wr <= mem_addr; last_wd <= mem_wdata; end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [39:0] pfn, input bit p, w, u, a, d, ps, xd);
        return {xd, 11'b0, pfn, 4'b0, ps, d, a, 2'b0, u, w, p};
    endfunction

    function automatic logic [51:0] eaddr(input logic [39:0] tb, input logic [8:0] idx);
        return {tb, idx, 3'b000};
    endfunction

    function automatic logic [47:0] mkva(input logic [8:0] i3, i2, i1, i0);
        return {i3, i2, i1, i0, 12'h0};
    endfunction

    task automatic setup(input logic [47:0] va, input logic [63:0] e3, e2, e1, e0);
        mem.delete();
        mem[longint'(eaddr(ROOT, va[47:39]))] = e3;
        mem[longint'(eaddr(T2,   va[38:30]))] = e2;
        mem[longint'(eaddr(T1,   va[29:21]))] = e1;
        mem[longint'(eaddr(T0,   va[20:12]))] = e0;
    endtask

    task automatic walk(input logic [47:0] va, input logic [1:0] acc, input bit usr);
        int n, r0, w0;
        @(negedge clk);
        r0 = rd_total; w0 = wr_total;
        req_vaddr = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        g_busy = req_ready;
        n = 0;
        while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
        g_valid = rsp_valid; g_fault = rsp_fault; g_code = rsp_fcode; g_lvl = rsp_flevel;
        g_pfn = rsp_pfn; g_size = rsp_size; g_w = rsp_w; g_u = rsp_u; g_xd = rsp_xd;
        g_rd = rd_total - r0; g_wr = wr_total - w0;
        @(negedge clk);
        g_pulse = rsp_valid;
    endtask

    initial begin
        logic [47:0] va;
        logic [63:0] up3, up2, up1, leaf;
        int ecode, ewr;
        va  = mkva(9'd5, 9'd7, 9'd9, 9'd11);
        up3 = mk(T2, 1, 1, 1, 1, 0, 0, 0);
        up2 = mk(T1, 1, 1, 1, 1, 0, 0, 0);
        up1 = mk(T0, 1, 1, 1, 1, 0, 0, 0);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R14",
            "reset state", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

        // 4 KiB sweep: leaf flags x access kind x mode
        for (int fl = 0; fl < 32; fl++) begin
            for (int acc = 0; acc < 3; acc++) begin
                for (int usr = 0; usr < 2; usr++) begin
                    bit w, u, x, a, d;
                    w = fl[0]; u = fl[1]; x = fl[2]; a = fl[3]; d = fl[4];
                    leaf = mk(LEAF, 1, w, u, a, d, 0, x);
                    setup(va, up3, up2, up1, leaf);
                    walk(va, 2'(acc), usr[0]);
                    if (usr == 1 && !u) ecode = 2;
                    else if (acc == 1 && !w) ecode = 1;
                    else if (acc == 2 && x) ecode = 3;
                    else ecode = -1;
                    chk(g_busy === 1'b0, "R1", "ready while busy", g_busy, 0);
                    chk(g_valid === 1'b1 && g_pulse === 1'b0, "R14", "pulse", {g_valid, g_pulse}, 2'b10);
                    chk(g_rd == 4 && last_rd == eaddr(T0, va[20:12]), "R2", "reads/last addr",
                        {g_rd[11:0], last_rd}, {12'd4, eaddr(T0, va[20:12])});
                    if (ecode >= 0) begin
                        chk(g_fault === 1'b1 && g_code == 2'(ecode) && g_lvl == 2'd0,
                            ecode == 2 ? "R7" : (ecode == 1 ? "R8" : "R9"), "fault code/level",
                            {g_fault, g_code, g_lvl}, {1'b1, 2'(ecode), 2'd0});
                        chk(g_wr == 0, "R12", "write on fault", g_wr, 0);
                    end else begin
                        chk(g_fault === 1'b0 && g_pfn == LEAF && g_size == 2'd0, "R3", "4K result",
                            {g_fault, g_size, g_pfn}, {1'b0, 2'd0, LEAF});
                        chk({g_w, g_u, g_xd} == {w, u, x}, "R13", "perms", {g_w, g_u, g_xd}, {w, u, x});
                        ewr = (!a || (acc == 1 && !d)) ? 1 : 0;
                        chk(g_wr == ewr, ewr ? "R10" : "R12", "write count", g_wr, ewr);
                        if (ewr == 1) begin
                            logic [63:0] ew;
                            ew = leaf | 64'h20 | ((acc == 1) ? 64'h40 : 64'h0);
                            chk(last_wr == eaddr(T0, va[20:12]) && last_wd == ew,
                                acc == 1 ? "R11" : "R10", "write-back", last_wd, ew);
                        end
                    end
                end
            end
        end

        // missing entry at each level
        for (int lv = 3; lv >= 0; lv--) begin
            setup(va, lv == 3 ? (up3 & ~64'h1) : up3, lv == 2 ? (up2 & ~64'h1) : up2,
                  lv == 1 ? (up1 & ~64'h1) : up1,
                  lv == 0 ? 64'h0 : mk(LEAF, 1, 1, 1, 1, 1, 0, 0));
            walk(va, 2'd1, 1'b1);
            chk(g_fault === 1'b1 && g_code == 2'd0 && g_lvl == 2'(lv), "R6", "not-present",
                {g_fault, g_code, g_lvl}, {1'b1, 2'd0, 2'(lv)});
            chk(g_rd == 4 - lv && g_wr == 0, "R6", "reads stop", g_rd, 4 - lv);
        end

        // inherited permissions from upper levels
        leaf = mk(LEAF, 1, 1, 1, 1, 1, 0, 0);
        setup(va, up3, mk(T1, 1, 0, 1, 1, 0, 0, 0), up1, leaf);
        walk(va, 2'd1, 1'b0);
        chk(g_fault && g_code == 2'd1 && g_lvl == 2'd2, "R8", "upper read-only",
            {g_code, g_lvl}, {2'd1, 2'd2});
        setup(va, mk(T2, 1, 1, 0, 1, 0, 0, 0), up2, up1, leaf);
        walk(va, 2'd0, 1'b1);
        chk(g_fault && g_code == 2'd2 && g_lvl == 2'd3, "R7", "upper supervisor",
            {g_code, g_lvl}, {2'd2, 2'd3});
        setup(va, up3, up2, mk(T0, 1, 1, 1, 1, 0, 0, 1), leaf);
        walk(va, 2'd2, 1'b0);
        chk(g_fault && g_code == 2'd3 && g_lvl == 2'd1, "R9", "upper no-exec",
            {g_code, g_lvl}, {2'd3, 2'd1});
        walk(va, 2'd0, 1'b0);
        chk(!g_fault && g_xd && g_w && g_u, "R13", "xd inherited", {g_fault, g_xd}, 2'b01);

        // 2 MiB pages over several offsets; frame low bits in the entry are ignored
        for (int k = 0; k < 4; k++) begin
            logic [8:0] i0;
            logic [47:0] v2;
            logic [39:0] ep;
            i0 = (k == 0) ? 9'd0 : (k == 1) ? 9'd1 : (k == 2) ? 9'd255 : 9'd511;
            v2 = mkva(9'd5, 9'd7, 9'd9, i0);
            setup(v2, up3, up2, mk(40'h4C01F, 1, 1, 1, 1, 1, 1, 0), 64'h0);
            walk(v2, 2'd1, 1'b1);
            ep = {31'(40'h4C01F >> 9), i0};
            chk(!g_fault && g_size == 2'd1 && g_pfn == ep && g_rd == 3 && g_wr == 0, "R4",
                "2M page", {g_size, g_pfn}, {2'd1, ep});
        end

        // 1 GiB pages over several offsets
        for (int k = 0; k < 4; k++) begin
            logic [8:0] i1, i0;
            logic [47:0] v1;
            logic [39:0] ep;
            i1 = 9'(k * 170); i0 = 9'(511 - k * 100);
            v1 = mkva(9'd5, 9'd7, i1, i0);
            setup(v1, up3, mk(40'h8BEEF, 1, 1, 1, 1, 1, 1, 0), 64'h0, 64'h0);
            walk(v1, 2'd0, 1'b0);
            ep = {22'(40'h8BEEF >> 18), i1, i0};
            chk(!g_fault && g_size == 2'd2 && g_pfn == ep && g_rd == 2, "R5",
                "1G page", {g_size, g_pfn}, {2'd2, ep});
        end

        finish_run();
    end
endmodule